// File: doc/BRIEF.md
# CAN Standby Bus Wakeup Detector

This block holds the mode and wakeup logic of a low-power CAN transceiver. A standby-select input chooses between normal and standby operation. A digitised bus-state input reports whether the differential bus is dominant. The block drives the receive-data output towards the protocol controller. In normal mode the receive output mirrors the bus. In standby mode the block ignores short bus activity. It reports a qualified wakeup as a low pulse on the receive output. That pulse is not latched and has a guaranteed minimum width.

Every time constant is counted in clock ticks: the wake filter, the flag delay, the release delay, the minimum pulse width and the standby-to-normal switch-over. A build parameter sets how a dominant bus that is already present at standby entry is handled. With `UNCOND_WAKE=1` that dominant wakes the node at once. With `UNCOND_WAKE=0` it must first return to recessive before any wakeup can be reported. A node on a shorted bus can then stay asleep.

Top module: `can_wake_detect`

## Requirements
- R1: Standby-select high (`stby_sel_i`=1) at a clock edge while in normal mode puts the block in standby mode from that edge on. Reset leaves the block in normal mode.
- R2: In normal mode `rxd_o` equals the inverse of `bus_dom_i` (1 = dominant) sampled at the previous clock edge.
- R3: In standby, only a dominant level sampled on more than `FILT_TICKS` consecutive edges qualifies as a wakeup. A shorter dominant run restarts the filter and leaves `rxd_o` high.
- R4: `rxd_o` goes low `FLAG_TICKS` edges after the qualifying edge, whatever the bus does in between. With the defaults, a dominant run starting at edge 1 gives `rxd_o` low first after edge 60.
- R5: The wakeup is not latched. Once the bus is recessive, `rxd_o` returns high after `REL_TICKS`+1 consecutive recessive samples, provided R6 is met. A new dominant sample restarts that count.
- R6: A wakeup low pulse on `rxd_o` lasts at least `MIN_PULSE_TICKS` cycles.
- R7: With `UNCOND_WAKE=1`, a dominant bus sampled at the standby entry edge drives `rxd_o` low right after that edge.
- R8: With `UNCOND_WAKE=0`, a dominant bus at the entry edge is ignored until a recessive sample is seen. After that, a new dominant run is filtered as in R3.
- R9: Standby is left only after `stby_sel_i` is sampled low on `SWITCH_TICKS` consecutive edges. Until then the standby behaviour of `rxd_o` is kept. After that `rxd_o` follows R2.
- R10: In standby, while no wakeup is being reported, `rxd_o` is high.
- R11: During and right after reset `rxd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stby_sel_i | input | 1 | 1 requests standby, 0 requests normal mode |
| bus_dom_i | input | 1 | Digitised bus state, 1 = dominant, 0 = recessive |
| rxd_o | output | 1 | Receive data / wakeup indication, low = dominant or wakeup |

## Verification
The hardest situation to reach is a standby entry while the bus is already dominant. The two build variants must then diverge. The bench instantiates both variants on the same inputs. It first drives the bus dominant in normal mode and only then raises standby-select, holding the dominant across the entry edge. A second hard case is a pending switch-over with bus activity running during the countdown. Dominant bursts shorter than the filter are applied during that countdown, so a premature mode change would show up as `rxd_o` following the bus.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;

    typedef enum logic [2:0] {
        W_IDLE    = 3'd0,
        W_FILTER  = 3'd1,
        W_FLAG    = 3'd2,
        W_ACTIVE  = 3'd3,
        W_RELEASE = 3'd4,
        W_BLOCKED = 3'd5
    } wake_st_e;

    // States in which a wakeup is shown as a low receive output
    function automatic logic st_reports_low(wake_st_e s);
        return (s == W_ACTIVE) || (s == W_RELEASE);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cwd_mode_ctrl.sv
module cwd_mode_ctrl #(
    parameter int unsigned SWITCH_TICKS = 75
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stby_sel_i,
    output logic stby_o,
    output logic enter_o,
    output logic leave_o
);
    localparam int unsigned SW_W    = $clog2(SWITCH_TICKS + 1);
    localparam logic [SW_W-1:0] SW_LAST = SW_W'(SWITCH_TICKS - 1);

    logic            stby_q;
    logic [SW_W-1:0] sw_cnt_q;

    assign enter_o = stby_sel_i && !stby_q;
    assign leave_o = stby_q && !stby_sel_i && (sw_cnt_q == SW_LAST);
    assign stby_o  = stby_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stby_q   <= 1'b0;
            sw_cnt_q <= '0;
        end else if (enter_o) begin
            stby_q   <= 1'b1;
            sw_cnt_q <= '0;
        end else if (leave_o) begin
            stby_q   <= 1'b0;
            sw_cnt_q <= '0;
        end else if (stby_q && !stby_sel_i) begin
            sw_cnt_q <= sw_cnt_q + 1'b1;
        end else begin
            sw_cnt_q <= '0;
        end
    end

    // R1: a standby request in normal mode takes effect at the next edge
    p_enter_next_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (stby_sel_i && !stby_q) |=> stby_q);

    // R9: standby is kept while the switch-over window is still open
    p_hold_switch_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (stby_q && !stby_sel_i && (sw_cnt_q != SW_LAST)) |=> stby_q);

endmodule

// File: rtl/cwd_wake_fsm.sv
module cwd_wake_fsm
    import can_wake_pkg::*;
#(
    parameter int unsigned FILT_TICKS      = 25,
    parameter int unsigned FLAG_TICKS      = 34,
    parameter int unsigned REL_TICKS       = 29,
    parameter int unsigned MIN_PULSE_TICKS = 50,
    parameter bit          UNCOND_WAKE     = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bus_dom_i,
    input  logic stby_i,
    input  logic enter_i,
    input  logic leave_i,
    output logic wake_low_o
);
    localparam int unsigned CNT_MAX = max3(FILT_TICKS, FLAG_TICKS, REL_TICKS);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam int unsigned PW      = $clog2(MIN_PULSE_TICKS + 1);
    localparam logic [CW-1:0] FILT_C = CW'(FILT_TICKS);
    localparam logic [CW-1:0] FLAG_C = CW'(FLAG_TICKS);
    localparam logic [CW-1:0] REL_C  = CW'(REL_TICKS);
    localparam logic [PW-1:0] MIN_C  = PW'(MIN_PULSE_TICKS);

    wake_st_e        st_q, st_n;
    wake_st_e        dom_entry_st;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic [PW-1:0]   pulse_q, pulse_n;

    // Variant choice for a dominant bus seen at standby entry
    generate
        if (UNCOND_WAKE) begin : g_uncond
            assign dom_entry_st = W_ACTIVE;
            // R7: dominant at entry is shown at once
            p_entry_wake_r7: assert property (@(posedge clk_i) disable iff (rst_i)
                (enter_i && bus_dom_i) |=> wake_low_o);
        end else begin : g_cond
            assign dom_entry_st = W_BLOCKED;
            // R8: dominant at entry does not wake the node
            p_entry_block_r8: assert property (@(posedge clk_i) disable iff (rst_i)
                (enter_i && bus_dom_i) |=> !wake_low_o);
        end
    endgenerate

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (enter_i) begin
            st_n  = bus_dom_i ? dom_entry_st : W_IDLE;
            cnt_n = '0;
        end else if (leave_i || !stby_i) begin
            st_n  = W_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (bus_dom_i) begin
                        st_n  = W_FILTER;
                        cnt_n = CW'(1);
                    end
                end
                W_FILTER: begin
                    if (!bus_dom_i) begin
                        st_n  = W_IDLE;
                        cnt_n = '0;
                    end else if (cnt_q >= FILT_C) begin
                        st_n  = W_FLAG;
                        cnt_n = CW'(1);
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                W_FLAG: begin
                    if (cnt_q >= FLAG_C) begin
                        st_n  = bus_dom_i ? W_ACTIVE : W_RELEASE;
                        cnt_n = bus_dom_i ? '0 : CW'(1);
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                W_ACTIVE: begin
                    if (!bus_dom_i) begin
                        st_n  = W_RELEASE;
                        cnt_n = CW'(1);
                    end
                end
                W_RELEASE: begin
                    if (bus_dom_i) begin
                        st_n  = W_ACTIVE;
                        cnt_n = '0;
                    end else if ((cnt_q >= REL_C) && (pulse_q >= MIN_C)) begin
                        st_n  = W_IDLE;
                        cnt_n = '0;
                    end else if (cnt_q < REL_C) begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                W_BLOCKED: begin
                    if (!bus_dom_i) begin
                        st_n  = W_IDLE;
                        cnt_n = '0;
                    end
                end
                default: begin
                    st_n  = W_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // Pulse-width counter: edges elapsed since the low indication began
    always_comb begin
        pulse_n = pulse_q;
        if (!st_reports_low(st_n)) begin
            pulse_n = '0;
        end else if (!st_reports_low(st_q)) begin
            pulse_n = PW'(1);
        end else if (pulse_q < MIN_C) begin
            pulse_n = pulse_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= W_IDLE;
            cnt_q   <= '0;
            pulse_q <= '0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            pulse_q <= pulse_n;
        end
    end

    assign wake_low_o = st_reports_low(st_q);

    // R3: a low indication never starts straight from the idle state
    p_no_direct_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == W_IDLE && !enter_i) |=> !wake_low_o);

    // R6: a pulse that ends without a mode change was long enough
    p_min_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(wake_low_o) && !$past(rst_i) && !$past(leave_i)) |-> ($past(pulse_q) >= MIN_C));

    // R8: a blocked bus stays blocked while it remains dominant
    p_blocked_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == W_BLOCKED && bus_dom_i && stby_i && !leave_i && !enter_i) |=> (st_q == W_BLOCKED));

endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
    import can_wake_pkg::*;
#(
    parameter int unsigned FILT_TICKS      = 25,
    parameter int unsigned FLAG_TICKS      = 34,
    parameter int unsigned REL_TICKS       = 29,
    parameter int unsigned MIN_PULSE_TICKS = 50,
    parameter int unsigned SWITCH_TICKS    = 75,
    parameter bit          UNCOND_WAKE     = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stby_sel_i,
    input  logic bus_dom_i,
    output logic rxd_o
);
    logic stby_q;
    logic enter_s;
    logic leave_s;
    logic wake_low_s;
    logic nrm_rxd_q;

    cwd_mode_ctrl #(
        .SWITCH_TICKS(SWITCH_TICKS)
    ) i_mode (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .stby_sel_i(stby_sel_i),
        .stby_o    (stby_q),
        .enter_o   (enter_s),
        .leave_o   (leave_s)
    );

    cwd_wake_fsm #(
        .FILT_TICKS     (FILT_TICKS),
        .FLAG_TICKS     (FLAG_TICKS),
        .REL_TICKS      (REL_TICKS),
        .MIN_PULSE_TICKS(MIN_PULSE_TICKS),
        .UNCOND_WAKE    (UNCOND_WAKE)
    ) i_wake (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bus_dom_i (bus_dom_i),
        .stby_i    (stby_q),
        .enter_i   (enter_s),
        .leave_i   (leave_s),
        .wake_low_o(wake_low_s)
    );

    // Normal-mode receive path: one register stage, inverted bus level
    always_ff @(posedge clk_i) begin
        if (rst_i) nrm_rxd_q <= 1'b1;
        else       nrm_rxd_q <= !bus_dom_i;
    end

    assign rxd_o = stby_q ? !wake_low_s : nrm_rxd_q;

    // R2: in steady normal mode the output is the previous inverted bus sample
    p_normal_follow_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stby_q && !$past(stby_q) && !$past(rst_i)) |-> (rxd_o == !$past(bus_dom_i)));

    // R10: standby without a pending wakeup keeps the output high
    p_stby_idle_high_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (stby_q && !wake_low_s) |-> rxd_o);

endmodule

// File: tb/test_can_wake_detect.sv
module test_can_wake_detect;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 25;
    localparam int FLAG = 34;
    localparam int REL  = 29;
    localparam int MINP = 50;
    localparam int SW   = 75;
    localparam int P_IDLE = 0, P_FILT = 1, P_FLAG = 2, P_LOW = 3, P_BLK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic bus = 1'b0;
    logic rxd_c, rxd_u;

    int checks = 0;
    int errors = 0;
    string req = "R11";
    int lc = 0, lu = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_wake_detect #(.FILT_TICKS(FILT), .FLAG_TICKS(FLAG), .REL_TICKS(REL),
        .MIN_PULSE_TICKS(MINP), .SWITCH_TICKS(SW), .UNCOND_WAKE(1'b0))
    i_can_wake_detect (.clk_i(clk), .rst_i(rst), .stby_sel_i(stb), .bus_dom_i(bus), .rxd_o(rxd_c));

    can_wake_detect #(.FILT_TICKS(FILT), .FLAG_TICKS(FLAG), .REL_TICKS(REL),
        .MIN_PULSE_TICKS(MINP), .SWITCH_TICKS(SW), .UNCOND_WAKE(1'b1))
    i_can_wake_detect_unc (.clk_i(clk), .rst_i(rst), .stby_sel_i(stb), .bus_dom_i(bus), .rxd_o(rxd_u));

    // Behavioural reference: index 0 = conditioned, 1 = unconditioned
    int  m_phase [2];
    int  m_run   [2];
    int  m_pulse [2];
    int  m_rec   [2];
    bit  m_stby;
    int  m_lowsel;
    bit  m_nrx;

    task automatic check(input string r, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", r, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit go_in, go_out;
        if (rst) begin
            m_stby = 0; m_lowsel = 0; m_nrx = 1;
            for (int v = 0; v < 2; v++) begin
                m_phase[v] = P_IDLE; m_run[v] = 0; m_pulse[v] = 0; m_rec[v] = 0;
            end
        end else begin
            go_in  = stb && !m_stby;
            go_out = m_stby && !stb && (m_lowsel + 1 == SW);
            for (int v = 0; v < 2; v++) begin
                if (go_in) begin
                    m_run[v] = 0; m_rec[v] = 0; m_pulse[v] = 0;
                    if (!bus)        m_phase[v] = P_IDLE;
                    else if (v == 1) begin m_phase[v] = P_LOW; m_pulse[v] = 1; end
                    else             m_phase[v] = P_BLK;
                end else if (go_out || !m_stby) begin
                    m_phase[v] = P_IDLE; m_run[v] = 0; m_pulse[v] = 0; m_rec[v] = 0;
                end else begin
                    case (m_phase[v])
                        P_IDLE: if (bus) begin m_phase[v] = P_FILT; m_run[v] = 1; end
                        P_FILT: begin
                            if (!bus) m_phase[v] = P_IDLE;
                            else if (m_run[v] >= FILT) begin m_phase[v] = P_FLAG; m_run[v] = 1; end
                            else m_run[v]++;
                        end
                        P_FLAG: begin
                            if (m_run[v] >= FLAG) begin
                                m_phase[v] = P_LOW; m_pulse[v] = 1; m_rec[v] = bus ? 0 : 1;
                            end else m_run[v]++;
                        end
                        P_LOW: begin
                            if (bus) begin m_rec[v] = 0; m_pulse[v]++; end
                            else begin
                                m_rec[v]++;
                                if (m_rec[v] > REL && m_pulse[v] >= MINP) begin
                                    m_phase[v] = P_IDLE; m_pulse[v] = 0; m_rec[v] = 0;
                                end else m_pulse[v]++;
                            end
                        end
                        P_BLK: if (!bus) m_phase[v] = P_IDLE;
                        default: m_phase[v] = P_IDLE;
                    endcase
                end
            end
            if (go_in) begin m_stby = 1; m_lowsel = 0; end
            else if (go_out) begin m_stby = 0; m_lowsel = 0; end
            else if (m_stby && !stb) m_lowsel++;
            else m_lowsel = 0;
            m_nrx = !bus;
        end
    end

    // Every-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(req, rxd_c, m_stby ? (m_phase[0] != P_LOW) : m_nrx, "cond model");
            check(req, rxd_u, m_stby ? (m_phase[1] != P_LOW) : m_nrx, "uncond model");
            if (!rxd_c) lc++;
            if (!rxd_u) lu++;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        int sc, su;
        step(3);
        rst = 1'b0;
        step(1);
        check("R11", rxd_c, 1'b1, "reset high cond");
        check("R11", rxd_u, 1'b1, "reset high uncond");

        req = "R2";
        bus = 1'b1; step(1);
        check("R2", rxd_c, 1'b0, "normal follows dominant");
        bus = 1'b0; step(1);
        check("R2", rxd_u, 1'b1, "normal follows recessive");
        for (int k = 0; k < 20; k++) begin
            bus = (k % 3 == 0); step(1);
        end
        bus = 1'b0; step(2);

        req = "R10";
        stb = 1'b1; step(10);
        check("R10", rxd_c, 1'b1, "standby idle high");

        req = "R3";
        sc = lc; su = lu;
        bus = 1'b1; step(20); bus = 1'b0; step(10);
        bus = 1'b1; step(FILT); bus = 1'b0; step(10);
        check("R3", (lc == sc) && (lu == su), 1'b1, "short dominant gives no wake");

        req = "R4";
        sc = lc; su = lu;
        bus = 1'b1; step(FILT + 1); bus = 1'b0; step(FLAG - 1);
        check("R4", rxd_c, 1'b1, "still high before flag delay");
        step(1);
        check("R4", rxd_c, 1'b0, "low after flag delay");
        req = "R6";
        step(100);
        check("R6", lc - sc == MINP, 1'b1, "pulse width equals minimum cond");
        check("R6", lu - su == MINP, 1'b1, "pulse width equals minimum uncond");

        req = "R5";
        sc = lc;
        bus = 1'b1; step(200); bus = 1'b0; step(100);
        check("R5", lc - sc == 200 + REL - FILT - FLAG, 1'b1, "release after recessive delay");
        check("R5", rxd_c, 1'b1, "not latched");

        req = "R9";
        sc = lc;
        stb = 1'b0;
        for (int k = 0; k < 7; k++) begin
            bus = 1'b1; step(5); bus = 1'b0; step(5);
        end
        bus = 1'b1; step(3);
        check("R9", rxd_c, 1'b1, "standby kept during switch-over");
        check("R9", lc == sc, 1'b1, "no low during switch-over");
        step(2);
        check("R9", rxd_c, 1'b0, "normal after switch-over");

        req = "R7";
        bus = 1'b1; step(2);
        stb = 1'b1; step(1);
        check("R7", rxd_u, 1'b0, "uncond wakes at entry");
        check("R8", rxd_c, 1'b1, "cond ignores dominant at entry");
        req = "R8";
        step(99);
        check("R8", rxd_c, 1'b1, "cond blocked on held dominant");
        check("R7", rxd_u, 1'b0, "uncond held low");
        bus = 1'b0; step(60);
        check("R7", rxd_u, 1'b1, "uncond released");
        sc = lc;
        bus = 1'b1; step(40); bus = 1'b0; step(100);
        check("R8", lc - sc == MINP, 1'b1, "cond wakes on later dominant");

        req = "R1";
        stb = 1'b0; step(SW + 5);
        stb = 1'b1; bus = 1'b1; step(1);
        check("R1", rxd_c, 1'b1, "standby entered at next edge");
        bus = 1'b0; step(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule